// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This block keeps wall-clock time as a 32-bit count of seconds. It runs from a slow crystal tick of roughly 33.33 kHz. That tick reaches the block as a single-cycle enable pulse in the system clock domain, and every counter advances only on that pulse. A calibration register gives the number of crystal ticks that make up one second. It can also stretch some seconds by one tick, which trims the long-run rate.

Software sets the time by writing a seconds value. The value does not reach the current-time register at once. It is copied there at the next second boundary. Until a sticky status bit shows that a second has passed, software reads the time from the set-time readback register. Writing the calibration register restarts the sub-second counter, so the first boundary after a write falls exactly one full period later. A control register holds a single battery-enable bit. The bus side is a synchronous register port: address, write enable, 32-bit write data, and 32-bit read data returned one cycle after the address.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset, current time and set-time readback read 0, calibration reads 0x198233, and status and control read 0.
- R2: Read data for an address appears on `bus_rdata` one clock later. Offset 0x00 (set-time, write only) and every unmapped offset read as 0.
- R3: A write to offset 0x00 is visible at once at readback offset 0x04. Current time (offset 0x10) keeps its value until the next second boundary, and at that boundary it takes the written value.
- R4: At a second boundary with no pending load, current time increases by exactly one.
- R5: With the fraction disabled, a second boundary occurs on every Nth `tick_en` pulse, where N is calibration bits 15:0. Clock cycles without `tick_en` do not advance the counter.
- R6: A write to the calibration offset 0x08 keeps only bits 20:0. Offset 0x08 reads back the stored 21-bit value.
- R7: A calibration write clears the sub-second counter and the 16-second fraction frame. The next boundary comes after exactly N further pulses. A pulse in the same cycle as the write does not count.
- R8: When calibration bit 20 is set and bits 19:16 hold F, the first F seconds of each 16-second frame last N+1 pulses and the rest last N.
- R9: Status bit 0 at offset 0x20 is set at every second boundary and stays set. Writing 1 to bit 0 clears it. Writing 0 leaves it unchanged. A boundary in the same cycle as a clear leaves it set.
- R10: Control bit 31 at offset 0x40 is read/write. All other control bits read 0.
- R11: A set-time write in the same cycle as a boundary does not affect that boundary. The boundary acts on the earlier state, and the new value loads at the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Crystal tick, one-cycle enable pulse |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after address |

## Verification
Three things are hard to reach from the ports: a write that lands in the same clock as the tick that closes a second, the stretched seconds of the fraction frame, and the restart of the period by a calibration write. With the default period, a second would take tens of thousands of pulses. The stimulus therefore first programs a period of five ticks, so that each boundary can be reached by counting pulses. It then issues a tick and a register write together in one cycle, for set-time, status clear and calibration in turn, and reads back at once. With a fraction of two, three consecutive seconds show the six-six-five tick pattern.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int PER_W   = 16;
  localparam int FRAC_W  = 4;
  localparam int CAL_W   = PER_W + FRAC_W + 1;
  localparam logic [CAL_W-1:0] CAL_RST = 21'h198233;

  localparam logic [ADDR_W-1:0] OFS_SET_WR = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SET_RD = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CAL    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_NOW    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h40;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cal_we,
  input  logic [CAL_W-1:0] cal_i,
  output logic             sec_tick
);
  localparam int CNT_W = PER_W + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d, period, cnt_inc;
  logic [FRAC_W-1:0] idx_q, idx_d;
  logic              extra, hit;

  always_comb begin
    extra   = cal_i[CAL_W-1] && (idx_q < cal_i[PER_W +: FRAC_W]);
    period  = {1'b0, cal_i[PER_W-1:0]} + {{(CNT_W-1){1'b0}}, extra};
    cnt_inc = cnt_q + 1'b1;
    hit     = (cnt_inc >= period);
    sec_tick = tick_en && hit && !cal_we;

    cnt_d = cnt_q;
    idx_d = idx_q;
    if (cal_we) begin
      cnt_d = '0;
      idx_d = '0;
    end else if (tick_en) begin
      cnt_d = hit ? '0 : cnt_inc;
      if (hit) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  p_cnt_below_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (cnt_q < period));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_we |=> (cnt_q == '0));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cal_we) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [DATA_W-1:0] set_data,
  input  logic              sec_tick,
  output logic [DATA_W-1:0] now_o,
  output logic [DATA_W-1:0] set_o
);
  logic [DATA_W-1:0] now_q, now_d, set_q, set_d;
  logic              pend_q, pend_d;

  always_comb begin
    set_d  = set_we ? set_data : set_q;
    now_d  = now_q;
    pend_d = pend_q;
    if (sec_tick) begin
      now_d  = pend_q ? set_q : now_q + 1'b1;
      pend_d = 1'b0;
    end
    if (set_we) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= '0;
      set_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      now_q  <= now_d;
      set_q  <= set_d;
      pend_q <= pend_d;
    end
  end

  assign now_o = now_q;
  assign set_o = set_q;

  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(now_q));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && pend_q) |=> (now_q == $past(set_q)));
  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !pend_q) |=> (now_q == $past(now_q) + 1'b1));
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              we_set, we_cal, we_stat, we_ctrl;
  logic [CAL_W-1:0]  cal_q, cal_d;
  logic              stat_q, stat_d, bat_q, bat_d;
  logic              sec_tick;
  logic [DATA_W-1:0] now_w, set_w, rd_d, rd_q;

  always_comb begin
    we_set  = bus_we && (bus_addr == OFS_SET_WR);
    we_cal  = bus_we && (bus_addr == OFS_CAL);
    we_stat = bus_we && (bus_addr == OFS_STAT);
    we_ctrl = bus_we && (bus_addr == OFS_CTRL);
  end

  rtc_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cal_we   (we_cal),
    .cal_i    (cal_q),
    .sec_tick (sec_tick)
  );

  rtc_timekeeper u_tk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (we_set),
    .set_data (bus_wdata),
    .sec_tick (sec_tick),
    .now_o    (now_w),
    .set_o    (set_w)
  );

  always_comb begin
    cal_d  = we_cal ? bus_wdata[CAL_W-1:0] : cal_q;
    bat_d  = we_ctrl ? bus_wdata[DATA_W-1] : bat_q;
    stat_d = stat_q;
    if (we_stat && bus_wdata[0]) stat_d = 1'b0;
    if (sec_tick)                stat_d = 1'b1;

    case (bus_addr)
      OFS_SET_RD: rd_d = set_w;
      OFS_CAL:    rd_d = {{(DATA_W-CAL_W){1'b0}}, cal_q};
      OFS_NOW:    rd_d = now_w;
      OFS_STAT:   rd_d = {{(DATA_W-1){1'b0}}, stat_q};
      OFS_CTRL:   rd_d = {bat_q, {(DATA_W-1){1'b0}}};
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= CAL_RST;
      stat_q <= 1'b0;
      bat_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      cal_q  <= cal_d;
      stat_q <= stat_d;
      bat_q  <= bat_d;
      rd_q   <= rd_d;
    end
  end

  assign bus_rdata = rd_q;

  p_status_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> stat_q);
  p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !we_stat) |=> stat_q);
  p_cal_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_cal |=> $stable(cal_q));
  p_ctrl_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ctrl |=> $stable(bat_q));
endmodule

// File: tb/sim_rtc_seconds_core.sv
module sim_rtc_seconds_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rtc_seconds_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2;
  localparam int NV = 43;
  // op, addr, data (ticks for OP_T), expected, requirement number
  localparam logic [77:0] VEC [NV] = '{
    {OP_R, 8'h10, 32'h0, 32'h0, 4'd1},          // R1 time
    {OP_R, 8'h08, 32'h0, 32'h198233, 4'd1},     // R1 calibration
    {OP_R, 8'h04, 32'h0, 32'h0, 4'd1},          // R1 readback
    {OP_R, 8'h20, 32'h0, 32'h0, 4'd1},          // R1 status
    {OP_R, 8'h40, 32'h0, 32'h0, 4'd1},          // R1 control
    {OP_R, 8'h00, 32'h0, 32'h0, 4'd2},          // R2 write-only
    {OP_R, 8'h7C, 32'h0, 32'h0, 4'd2},          // R2 unmapped
    {OP_W, 8'h08, 32'hFFE00005, 32'h0, 4'd6},   // R6 masked write
    {OP_R, 8'h08, 32'h0, 32'h5, 4'd6},
    {OP_T, 8'h00, 32'd4, 32'h0, 4'd5},          // R5 four pulses
    {OP_R, 8'h10, 32'h0, 32'h0, 4'd5},
    {OP_T, 8'h00, 32'd1, 32'h0, 4'd5},          // R5 fifth pulse
    {OP_R, 8'h10, 32'h0, 32'h1, 4'd4},
    {OP_R, 8'h20, 32'h0, 32'h1, 4'd9},          // R9 set
    {OP_W, 8'h20, 32'h0, 32'h0, 4'd9},
    {OP_R, 8'h20, 32'h0, 32'h1, 4'd9},          // R9 zero write
    {OP_W, 8'h20, 32'h1, 32'h0, 4'd9},
    {OP_R, 8'h20, 32'h0, 32'h0, 4'd9},          // R9 clear
    {OP_W, 8'h00, 32'h1000, 32'h0, 4'd3},
    {OP_R, 8'h04, 32'h0, 32'h1000, 4'd3},       // R3 readback
    {OP_R, 8'h10, 32'h0, 32'h1, 4'd3},          // R3 not yet
    {OP_T, 8'h00, 32'd5, 32'h0, 4'd3},
    {OP_R, 8'h10, 32'h0, 32'h1000, 4'd3},       // R3 loaded
    {OP_T, 8'h00, 32'd5, 32'h0, 4'd4},
    {OP_R, 8'h10, 32'h0, 32'h1001, 4'd4},       // R4
    {OP_T, 8'h00, 32'd3, 32'h0, 4'd7},
    {OP_W, 8'h08, 32'h5, 32'h0, 4'd7},          // R7 restart
    {OP_T, 8'h00, 32'd4, 32'h0, 4'd7},
    {OP_R, 8'h10, 32'h0, 32'h1001, 4'd7},
    {OP_T, 8'h00, 32'd1, 32'h0, 4'd7},
    {OP_R, 8'h10, 32'h0, 32'h1002, 4'd7},
    {OP_W, 8'h08, 32'h00120005, 32'h0, 4'd8},   // R8 fraction 2
    {OP_T, 8'h00, 32'd5, 32'h0, 4'd8},
    {OP_R, 8'h10, 32'h0, 32'h1002, 4'd8},
    {OP_T, 8'h00, 32'd1, 32'h0, 4'd8},
    {OP_R, 8'h10, 32'h0, 32'h1003, 4'd8},
    {OP_T, 8'h00, 32'd5, 32'h0, 4'd8},
    {OP_R, 8'h10, 32'h0, 32'h1003, 4'd8},
    {OP_T, 8'h00, 32'd1, 32'h0, 4'd8},
    {OP_R, 8'h10, 32'h0, 32'h1004, 4'd8},
    {OP_T, 8'h00, 32'd5, 32'h0, 4'd8},          // third second: 5 pulses
    {OP_R, 8'h10, 32'h0, 32'h1005, 4'd8},
    {OP_W, 8'h40, 32'hFFFFFFFF, 32'h0, 4'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); check(req, bus_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic with_tick);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_en = with_tick;
    @(negedge clk); bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      logic [77:0] e;
      e = VEC[v];
      case (e[77:76])
        OP_W: wr(e[75:68], e[67:36], 1'b0);
        OP_R: rd(e[75:68], e[35:4], $sformatf("R%0d vec%0d", e[3:0], v));
        default: ticks(int'(e[67:36]));
      endcase
    end
    rd(8'h40, 32'h80000000, "R10 bit31 set");
    wr(8'h40, 32'h0, 1'b0);
    rd(8'h40, 32'h0, "R10 bit31 cleared");

    // R11: set-time write coinciding with a boundary
    wr(8'h08, 32'h5, 1'b0);
    ticks(4);
    wr(8'h00, 32'h2000, 1'b1);
    rd(8'h10, 32'h1006, "R11 boundary uses old state");
    ticks(5);
    rd(8'h10, 32'h2000, "R11 load at next boundary");

    // R9: boundary and clear in one cycle, set wins
    wr(8'h20, 32'h1, 1'b0);
    ticks(4);
    wr(8'h20, 32'h1, 1'b1);
    rd(8'h20, 32'h1, "R9 set beats clear");

    // R7: calibration write with a pulse in the same cycle
    ticks(4);
    wr(8'h08, 32'h5, 1'b1);
    ticks(4);
    rd(8'h10, 32'h2001, "R7 no boundary before period");
    ticks(1);
    rd(8'h10, 32'h2002, "R7 boundary after period");

    // R5: cycles without pulses do not advance
    repeat (40) @(negedge clk);
    ticks(4);
    rd(8'h10, 32'h2002, "R5 idle cycles ignored");

    // R1: reset in the middle of a run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'h10, 32'h0, "R1 time after reset");
    rd(8'h08, 32'h198233, "R1 calibration after reset");
    rd(8'h04, 32'h0, "R1 readback after reset");
    finish_run();
  end
endmodule